// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block receives the header of a LIN frame on the slave side. It watches a serial input that is sampled sixteen times per bit, through a one-cycle enable. It looks for a long dominant run that marks the break. It then decodes the sync byte and takes the identifier byte. The whole header is timed from the first dominant sample of the break. A header that is complete, correctly framed and on time wakes the slave from mute, latches the identifier and raises the header-seen flag. Any other header outcome raises the header-fault flag and leaves the slave muted.

A one-cycle interrupt pulse marks each header outcome. A clear strobe resets both flags. The serial input must already be synchronised to `clk`. The recessive gap between the break and the sync field must last at least one sample tick.

Top module: `lin_hdr_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `mute` is 1, `hdr_seen` and `hdr_fault` are 0, `hdr_irq` is 0 and `frame_id` is 0x00.
- R2: A break is accepted only when `lin_rx` is sampled low on at least 13×16 = 208 consecutive ticks. A break has no upper length limit other than the header timeout. A shorter low run is ignored: it raises no flag, no pulse, and causes no mute change.
- R3: Within a byte, the first low tick of the start bit counts as sample 0. Each bit is the majority of its samples 7, 8 and 9. Bits arrive in the order start, eight data bits LSB first, stop. A start bit that is judged high is dropped and the receiver hunts for the next start bit.
- R4: The sync byte must decode to 0x55. Any other value sets `hdr_fault` and keeps `mute` at 1.
- R5: A stop bit judged low in the sync byte or the identifier byte is a framing error. It sets `hdr_fault` and keeps `mute` at 1.
- R6: On a valid header, `hdr_seen` rises, `frame_id` takes the identifier byte and `mute` falls, all at the same clock edge.
- R7: The first low tick of the break is tick 1. The header is valid only if the identifier stop-bit decision (sample 9 of that bit) lands on tick 912 (57×16) or earlier. Otherwise, on tick 913, `hdr_fault` is set, `hdr_seen` stays 0 and `mute` stays 1. This holds even when tick 913 falls inside the identifier stop bit.
- R8: `hdr_irq` pulses for exactly one cycle per accepted break, when the header outcome is known. Clearing `hdr_fault` after a timed-out header produces no further pulse and no flag.
- R9: `flag_clr` clears both flags. If a flag is set in the same cycle as `flag_clr`, the set wins.
- R10: `mute` returns to 1 as soon as a new break reaches 208 low ticks.
- R11: After a fault, the block waits for a recessive sample before it hunts for the next break. A valid header that follows is then received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Sample enable at 16 times the bit rate |
| lin_rx | input | 1 | Synchronised serial line, low is dominant |
| flag_clr | input | 1 | Clears `hdr_seen` and `hdr_fault` |
| hdr_seen | output | 1 | Valid header received |
| hdr_fault | output | 1 | Header timeout, sync mismatch or framing error |
| hdr_irq | output | 1 | One-cycle pulse per header outcome |
| frame_id | output | 8 | Identifier byte of the last valid header |
| mute | output | 1 | Slave muted; low after a valid header |

## Verification
A timer that is off by one tick moves the boundary between a valid and a timed-out header. This shows as a wrong flag at the end of a header whose identifier stop decision lands exactly on tick 912 or 913. A sampler whose phase is wrong corrupts the identifier or the sync check. This shows on `frame_id` or `hdr_fault` at the end of the first affected header, and sooner when one sample is flipped at the bit centre. A wrong state after a timeout shows as a second `hdr_irq` pulse, a stray `hdr_seen` or a dropped `mute`. Each of these appears within the same header.

// File: rtl/lin_hdr_pkg.sv
// Shared constants, controller state type and the bit-vote helper
// for the LIN header receiver.
package lin_hdr_pkg;

    localparam int DEF_OSR      = 16;   // samples per bit
    localparam int DEF_BRK_BITS = 13;   // minimum break length in bits
    localparam int DEF_HDR_BITS = 57;   // header length limit in bits
    localparam int BYTE_W       = 8;

    typedef enum logic [2:0] {
        S_IDLE,     // hunting for the first dominant sample
        S_BRK,      // inside a dominant run
        S_SYNC,     // receiving the sync byte
        S_ID,       // receiving the identifier byte
        S_WAIT_HI   // after a fault, waiting for a recessive line
    } hdr_state_e;

    // Majority of three samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lin_brk_det.sv
// Break detector. While armed, it measures dominant runs in sample ticks.
// Outputs are combinational and qualified by the tick of the current
// sample, so the controller reacts at the same clock edge.
// Assumes lin_rx is synchronous to clk.
module lin_brk_det #(
    parameter int BRK_TICKS = 208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx,
    input  logic arm,
    output logic first,      // first dominant sample of a run
    output logic len_ok,     // run has just reached BRK_TICKS
    output logic done,       // recessive after a long enough run
    output logic short_run   // recessive after a too-short run
);
    localparam int CW = $clog2(BRK_TICKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(BRK_TICKS);
    localparam logic [CW-1:0] CNT_PRE = CW'(BRK_TICKS - 1);

    logic          busy;
    logic [CW-1:0] cnt;

    // Decode run events from the current sample.
    always_comb begin
        first     = arm && !busy && tick && !rx;
        len_ok    = busy && tick && !rx && (cnt == CNT_PRE);
        done      = busy && tick && rx && (cnt == CNT_MAX);
        short_run = busy && tick && rx && (cnt < CNT_MAX);
    end

    // Count dominant ticks, saturating at the break length.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            if (!busy && !rx) begin
                busy <= 1'b1;
                cnt  <= CW'(1);
            end else if (busy && !rx) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else if (busy && rx) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lin_byte_smp.sv
// Oversampled byte sampler. While enabled, it waits for a start bit.
// It judges each bit by a majority of the three samples around the bit
// centre and shifts in the data bits LSB first. It flags the stop bit
// result at its decision sample. A start bit that is judged high is
// dropped. Assumes OSR >= 8.
module lin_byte_smp
    import lin_hdr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              en,
    output logic              byte_ok,    // stop bit judged high
    output logic              frame_bad,  // stop bit judged low
    output logic [BYTE_W-1:0] data
);
    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] PH_V1   = PW'(OSR/2 - 1);
    localparam logic [PW-1:0] PH_V2   = PW'(OSR/2);
    localparam logic [PW-1:0] PH_DEC  = PW'(OSR/2 + 1);
    localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);
    localparam logic [3:0]    BI_STOP = 4'(BYTE_W + 1);

    logic          busy;
    logic [PW-1:0] ph;
    logic [3:0]    bi;
    logic          s_a, s_b;
    logic          dec, bitv;

    // Decision sample and the voted bit value.
    always_comb begin
        dec       = en && busy && tick && (ph == PH_DEC);
        bitv      = vote3(s_a, s_b, rx);
        byte_ok   = dec && (bi == BI_STOP) && bitv;
        frame_bad = dec && (bi == BI_STOP) && !bitv;
    end

    // Track the sample phase and bit index, take votes and shift data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ph   <= '0;
            bi   <= '0;
            s_a  <= 1'b1;
            s_b  <= 1'b1;
            data <= '0;
        end else if (!en) begin
            busy <= 1'b0;
        end else if (tick) begin
            if (!busy) begin
                if (!rx) begin
                    busy <= 1'b1;
                    ph   <= PW'(1);
                    bi   <= '0;
                end
            end else begin
                if (ph == PH_LAST) begin
                    ph <= '0;
                    bi <= bi + 1'b1;
                end else begin
                    ph <= ph + 1'b1;
                end
                if (ph == PH_V1) s_a <= rx;
                if (ph == PH_V2) s_b <= rx;
                if (ph == PH_DEC) begin
                    if (bi == 4'd0 && bitv)  busy <= 1'b0;
                    if (bi != 4'd0 && bi != BI_STOP) data <= {bitv, data[BYTE_W-1:1]};
                    if (bi == BI_STOP)       busy <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/lin_hdr_tmr.sv
// Header length timer. Loads 1 on the first dominant sample of a break
// and counts sample ticks while the header is in progress. Expires on
// the tick after LIMIT ticks have passed.
module lin_hdr_tmr #(
    parameter int LIMIT = 912
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] T_LIM = CW'(LIMIT);
    localparam logic [CW-1:0] T_SAT = CW'(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Expiry on the tick numbered LIMIT+1.
    always_comb expired = run && tick && (cnt == T_LIM);

    // Load on a break start, otherwise count ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (run && tick && cnt != T_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lin_hdr_rx.sv
// LIN slave header receiver. It sequences break, sync byte and
// identifier byte under a whole-header timeout, and owns the flags,
// the interrupt pulse, the identifier register and the mute state.
// Assumes lin_rx is synchronised and the break delimiter lasts at
// least one sample tick.
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int          OSR      = DEF_OSR,
    parameter int          BRK_BITS = DEF_BRK_BITS,
    parameter int          HDR_BITS = DEF_HDR_BITS,
    parameter logic [7:0]  SYNC_VAL = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       lin_rx,
    input  logic       flag_clr,
    output logic       hdr_seen,
    output logic       hdr_fault,
    output logic       hdr_irq,
    output logic [7:0] frame_id,
    output logic       mute
);
    localparam int BRK_TICKS = OSR * BRK_BITS;
    localparam int HDR_TICKS = OSR * HDR_BITS;

    hdr_state_e        state, nxt;
    logic              brk_first, brk_len_ok, brk_done, brk_short;
    logic              smp_ok, smp_bad;
    logic [BYTE_W-1:0] smp_data;
    logic              hdr_tmo;
    logic              ev_ok, ev_err;
    logic              brk_arm, smp_en, tmr_run;

    // Enables handed to the sub-blocks.
    always_comb begin
        brk_arm = (state == S_IDLE) || (state == S_BRK);
        smp_en  = (state == S_SYNC) || (state == S_ID);
        tmr_run = (state == S_BRK) || smp_en;
    end

    lin_brk_det #(.BRK_TICKS(BRK_TICKS)) u_brk (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(lin_rx), .arm(brk_arm),
        .first(brk_first), .len_ok(brk_len_ok), .done(brk_done), .short_run(brk_short)
    );

    lin_byte_smp #(.OSR(OSR)) u_smp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(lin_rx), .en(smp_en),
        .byte_ok(smp_ok), .frame_bad(smp_bad), .data(smp_data)
    );

    lin_hdr_tmr #(.LIMIT(HDR_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .start(brk_first),
        .run(tmr_run), .expired(hdr_tmo)
    );

    // Next state and header outcome; the timeout has priority.
    always_comb begin
        nxt    = state;
        ev_ok  = 1'b0;
        ev_err = 1'b0;
        unique case (state)
            S_IDLE: if (brk_first) nxt = S_BRK;
            S_BRK: begin
                if (hdr_tmo)        begin ev_err = 1'b1; nxt = S_WAIT_HI; end
                else if (brk_done)  nxt = S_SYNC;
                else if (brk_short) nxt = S_IDLE;
            end
            S_SYNC: begin
                if (hdr_tmo || smp_bad) begin ev_err = 1'b1; nxt = S_WAIT_HI; end
                else if (smp_ok) begin
                    if (smp_data == SYNC_VAL) nxt = S_ID;
                    else begin ev_err = 1'b1; nxt = S_WAIT_HI; end
                end
            end
            S_ID: begin
                if (hdr_tmo || smp_bad) begin ev_err = 1'b1; nxt = S_WAIT_HI; end
                else if (smp_ok)        begin ev_ok  = 1'b1; nxt = S_IDLE; end
            end
            S_WAIT_HI: if (os_tick && lin_rx) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Controller state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Flags, interrupt pulse, identifier and mute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_seen  <= 1'b0;
            hdr_fault <= 1'b0;
            hdr_irq   <= 1'b0;
            frame_id  <= '0;
            mute      <= 1'b1;
        end else begin
            hdr_seen  <= ev_ok  | (hdr_seen  & ~flag_clr);
            hdr_fault <= ev_err | (hdr_fault & ~flag_clr);
            hdr_irq   <= ev_ok | ev_err;
            if (ev_ok) frame_id <= smp_data;
            if (ev_ok) mute <= 1'b0;
            else if (ev_err || (state == S_BRK && brk_len_ok)) mute <= 1'b1;
        end
    end

    // R8: the interrupt is never longer than one cycle.
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_irq |=> !hdr_irq);

    // R6: a new valid header comes with mute released.
    assert_seen_unmutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_seen) |-> !mute);

    // R7: mute drops only together with a valid-header event.
    assert_wake_needs_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> (hdr_irq && hdr_seen));

    // R6: the identifier register changes only on a valid header.
    assert_id_on_hdr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_id) |-> (hdr_irq && hdr_seen));

    // R7: a fault and a valid header never begin together.
    assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_fault) |-> !$rose(hdr_seen));

    // R10: the sync field is received only while muted.
    assert_sync_muted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SYNC && $past(state) == S_BRK) |-> mute);

endmodule

// File: tb/tb_lin_hdr_rx.sv
// Self-checking bench. Drives headers tick by tick and predicts the
// outcome from the tick arithmetic of the requirements.
module tb_lin_hdr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 912;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       lin_rx = 1'b1;
    logic       flag_clr = 1'b0;
    logic       hdr_seen, hdr_fault, hdr_irq, mute;
    logic [7:0] frame_id;

    int n_chk = 0, n_err = 0;
    int tno = 0, clr_at = 0, irq_cnt = 0;
    int last_id = 0;
    int exp_mute = 1;

    lin_hdr_rx dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .lin_rx(lin_rx),
        .flag_clr(flag_clr), .hdr_seen(hdr_seen), .hdr_fault(hdr_fault),
        .hdr_irq(hdr_irq), .frame_id(frame_id), .mute(mute)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sample tick: tick cycle, then an idle cycle.
    task automatic step(input logic lvl);
        tno++;
        lin_rx   = lvl;
        os_tick  = 1'b1;
        flag_clr = (clr_at != 0 && tno == clr_at);
        @(posedge clk); @(negedge clk);
        if (hdr_irq) irq_cnt++;
        os_tick  = 1'b0;
        flag_clr = 1'b0;
        @(posedge clk); @(negedge clk);
        if (hdr_irq) irq_cnt++;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop, input bit glitch);
        for (int b = 0; b < 10; b++) begin
            for (int p = 0; p < 16; p++) begin
                logic v;
                v = (b == 0) ? 1'b0 : (b == 9) ? stop : d[b-1];
                if (glitch && p == 8 && b >= 1 && b <= 8) v = ~v;
                step(v);
            end
        end
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Send a header and compare all outputs to the prediction.
    task automatic run_hdr(input string req, input int brk, input logic [7:0] sy,
                           input logic sstop, input logic [7:0] id, input logic istop,
                           input int gap, input bit glitch, input bit blip, input int clr_tick);
        int dec, e_ok, e_err, e_irq;
        bit brk_ok, valid;
        pulse_clr();
        tno = 0; irq_cnt = 0; clr_at = clr_tick;
        repeat (brk*16) step(1'b0);
        repeat (16) step(1'b1);
        send_byte(sy, sstop, 1'b0);
        for (int g = 0; g < gap; g++) step((blip && g < 4) ? 1'b0 : 1'b1);
        send_byte(id, istop, glitch);
        repeat (40) step(1'b1);
        clr_at = 0;
        dec    = brk*16 + 16 + gap + 314;
        brk_ok = (brk >= 13);
        valid  = brk_ok && sy == 8'h55 && sstop && istop && dec <= LIM;
        e_ok   = valid ? 1 : 0;
        e_err  = (brk_ok && !valid && !(clr_tick > LIM + 1)) ? 1 : 0;
        e_irq  = brk_ok ? 1 : 0;
        if (valid) begin exp_mute = 0; last_id = id; end
        else if (brk_ok) exp_mute = 1;
        check({req, " seen"},  int'(hdr_seen),  e_ok);
        check({req, " fault"}, int'(hdr_fault), e_err);
        check({req, " irq"},   irq_cnt,         e_irq);
        check({req, " id"},    int'(frame_id),  last_id);
        check({req, " mute"},  int'(mute),      exp_mute);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 mute", int'(mute), 1);
        check("R1 seen", int'(hdr_seen), 0);
        check("R1 fault", int'(hdr_fault), 0);
        check("R1 irq", int'(hdr_irq), 0);
        check("R1 id", int'(frame_id), 0);
        rst_n = 1'b1;
        repeat (20) step(1'b1);

        // R6 R3: valid headers, varied break, gap, id and centre glitch
        for (int i = 0; i < 12; i++)
            run_hdr("R6_R3 valid", 13 + (i % 4) * 3, 8'h55, 1'b1,
                    8'((i * 53 + 7) & 255), 1'b1, (i % 3) * 8, i[0], 1'b0, 0);

        // R9: clear of the header-seen flag keeps the identifier
        pulse_clr();
        check("R9 seen cleared", int'(hdr_seen), 0);
        check("R9 id kept", int'(frame_id), last_id);

        // R3: a short low blip before the identifier is a false start
        run_hdr("R3 false start", 13, 8'h55, 1'b1, 8'hA6, 1'b1, 24, 1'b0, 1'b1, 0);

        // R2: too-short break ignored while unmuted
        run_hdr("R2 short break", 12, 8'h55, 1'b1, 8'h3C, 1'b1, 0, 1'b0, 1'b0, 0);

        // R4 R10: sync mismatches re-mute
        run_hdr("R4_R10 sync 54", 13, 8'h54, 1'b1, 8'h11, 1'b1, 16, 1'b0, 1'b0, 0);
        run_hdr("R4 sync D5", 14, 8'hD5, 1'b1, 8'h22, 1'b1, 16, 1'b0, 1'b0, 0);
        run_hdr("R4 sync 00", 13, 8'h00, 1'b1, 8'h33, 1'b1, 16, 1'b0, 1'b0, 0);

        // R5: framing errors
        run_hdr("R5 sync stop", 13, 8'h55, 1'b0, 8'h44, 1'b1, 16, 1'b0, 1'b0, 0);
        run_hdr("R5 id stop", 13, 8'h55, 1'b1, 8'h45, 1'b0, 16, 1'b0, 1'b0, 0);

        // R7: sweep the identifier stop decision across tick 912/913
        for (int g = 368; g <= 381; g++)
            run_hdr("R7 boundary", 13, 8'h55, 1'b1, 8'(g), 1'b1, g, 1'b0, 1'b0, 0);

        // R8 R9: clear around a timeout that lands on the stop decision
        for (int c = LIM + 1; c <= LIM + 7; c++)
            run_hdr("R8_R9 clear", 13, 8'h55, 1'b1, 8'h5A, 1'b1, 375, 1'b0, 1'b0, c);

        // R2 R7: overlong break times out
        run_hdr("R2_R7 long break", 58, 8'h55, 1'b1, 8'h66, 1'b1, 0, 1'b0, 1'b0, 0);

        // R11: recovery after a fault
        run_hdr("R11 recover", 13, 8'h55, 1'b1, 8'hC3, 1'b1, 0, 1'b1, 1'b0, 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule